// File: doc/BRIEF.md
# Latched Event Statistics Counter Bank

This block keeps a bank of event counters, one per event input, each several bytes wide. The counters are read through a byte-wide register port with chip-select, read strobe and byte address. A read of a counter's low byte captures the remaining bytes into a shadow. Later reads of the higher bytes then return one consistent value, even while events keep arriving. Reading the low byte also clears the counter, so software that polls at a steady rate sees every event exactly once.

A mode register selects optional snapshot behaviour driven by a one-second tick. With counter snapshots enabled, every tick moves each counter into its own holding register and restarts the counter. Reads then see the held value, and a read of the low byte empties the holding register. With status snapshots enabled, the status byte returns the status inputs as sampled at the last tick.

The tick comes from one of two places. It is either a synchronized rising edge on an external one-second pin, or an internal divide-by-`DIV` of an 8 kHz reference that the block also drives onto that pin. A mode bit selects the pin direction.

Top module: `evstat_bank`

## Requirements
- R1: Each event pulse adds one to its counter. A counter at all-ones stays there; it never wraps.
- R2: Counter `i` byte `b` sits at address `CNT_BASE + CNT_BYTES*i + b` (byte 0 is least significant). A read of byte 0 stores the full value, and reads of bytes above 0 return that stored value, not the live count.
- R3: With counter snapshots off (mode bit 4 = 0), a byte-0 read clears the counter. An event in the same cycle as that read is kept, so the counter restarts at one.
- R4: With mode bit 4 = 1, each tick copies every counter into its holding register and clears the counter. An event in the tick cycle lands in the new interval. Counter reads return the holding register.
- R5: With mode bit 4 = 1, a byte-0 read clears the holding register. A read in the same cycle as a tick returns the newly captured value and does not clear it.
- R6: The status byte is at address 0x01, with status input k at bit k. With mode bit 5 = 1 it returns the status sampled at the last tick; otherwise it returns the live inputs.
- R7: With mode bit 0 = 1 the pin output is enabled. It carries the reference divided by `DIV`: low for `DIV/2` synchronized reference rising edges, then high for `DIV/2`. Its rising edge is the tick.
- R8: With mode bit 0 = 0 the pin output enable is low, and a rising edge on the pin input, after two synchronizing flops, is the tick.
- R9: Read data appears on the clock edge after the strobe is sampled and holds until the next strobe. A strobe held for several cycles has side effects only once.
- R10: The mode register is at 0x00. It is written via `wr_i`, keeps only bits 0, 4 and 5, and reads back as it was written, with its reset value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | NUM_CNT | One event pulse per counter per cycle |
| stat_i | input | NUM_STAT | Live status bits |
| ref8k_i | input | 1 | 8 kHz reference, asynchronous |
| sec_pin_i | input | 1 | One-second pin, input side |
| sec_pin_o | output | 1 | One-second pin, driven value |
| sec_pin_oe | output | 1 | One-second pin output enable |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |

## Verification
The checker watches several properties on every cycle:
- one read effect per strobe;
- read data holding between strobes;
- counters never falling except through a clear;
- each tick handing counter 0's value to its holding register;
- each divider-driven rise of the pin coinciding with a tick.

Other behaviour only the bench scenarios can show. These include coherent multi-byte values, saturation after a long burst, and whether an event or a read landing exactly on a tick or a clear is kept. They also include which register a read returns in each mode, and the pin's measured high time and period.

// File: rtl/evstat_bank.sv
module evstat_bank #(
  parameter int NUM_CNT   = 4,
  parameter int CNT_BYTES = 2,
  parameter int NUM_STAT  = 8,
  parameter int DIV       = 8000,
  parameter int ADDR_W    = 8,
  parameter int CNT_BASE  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CNT-1:0]  ev_i,
  input  logic [NUM_STAT-1:0] stat_i,
  input  logic              ref8k_i,
  input  logic              sec_pin_i,
  output logic              sec_pin_o,
  output logic              sec_pin_oe,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int CNT_W = 8 * CNT_BYTES;
  localparam int HALF  = DIV / 2;
  localparam int DIV_W = $clog2(DIV);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CNT_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_CNT * CNT_BYTES);
  localparam logic [ADDR_W-1:0] CB_A   = ADDR_W'(CNT_BYTES);

  logic [7:0] mode_q;
  logic [2:0] pin_s, ref_s;
  logic [DIV_W-1:0] div_q;
  logic rd_q;
  logic [NUM_STAT-1:0] stat_snap;
  logic [CNT_W-1:0] cnt_q [NUM_CNT];
  logic [CNT_W-1:0] lat_q [NUM_CNT];
  logic [CNT_W-1:0] shd_q [NUM_CNT];
  logic [CNT_W-1:0] src   [NUM_CNT];
  logic [NUM_CNT-1:0] rd_lsb;

  wire cnt_lat = mode_q[4];
  wire st_lat  = mode_q[5];
  wire pin_out = mode_q[0];

  wire ref_edge = ref_s[1] & ~ref_s[2];
  wire tick_div = ref_edge && (div_q == DIV_W'(HALF - 1));
  wire tick_pin = pin_s[1] & ~pin_s[2];
  wire tick     = pin_out ? tick_div : tick_pin;

  wire rd_fire = cs_i & rd_i & ~rd_q;
  wire wr_fire = cs_i & wr_i;

  wire [ADDR_W-1:0] off = addr_i - BASE_A;
  wire in_cnt = (addr_i >= BASE_A) && (off < SPAN_A);
  wire [ADDR_W-1:0] ci = off / CB_A;
  wire [ADDR_W-1:0] bi = off % CB_A;

  assign sec_pin_oe = pin_out;
  assign sec_pin_o  = (div_q >= DIV_W'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s <= '0;
      ref_s <= '0;
      div_q <= '0;
      rd_q  <= 1'b0;
      mode_q <= '0;
      stat_snap <= '0;
    end else begin
      pin_s <= {pin_s[1:0], sec_pin_i};
      ref_s <= {ref_s[1:0], ref8k_i};
      rd_q  <= cs_i & rd_i;
      if (ref_edge)
        div_q <= (div_q == DIV_W'(DIV - 1)) ? '0 : div_q + 1'b1;
      if (wr_fire && addr_i == '0)
        mode_q <= wdata_i & 8'h31;
      if (tick)
        stat_snap <= stat_i;
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic clr;
    logic [CNT_W-1:0] base;
    assign rd_lsb[i] = rd_fire && in_cnt && (ci == ADDR_W'(i)) && (bi == '0);
    assign src[i]    = (cnt_lat && !tick) ? lat_q[i] : cnt_q[i];
    assign clr       = cnt_lat ? tick : rd_lsb[i];
    assign base      = clr ? '0 : cnt_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
        lat_q[i] <= '0;
        shd_q[i] <= '0;
      end else begin
        cnt_q[i] <= (&base) ? base : base + CNT_W'(ev_i[i]);
        if (cnt_lat && tick)
          lat_q[i] <= cnt_q[i];
        else if (cnt_lat && rd_lsb[i])
          lat_q[i] <= '0;
        if (rd_lsb[i])
          shd_q[i] <= src[i];
      end
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr_i == '0)
      rd_mux = mode_q;
    else if (addr_i == ADDR_W'(1))
      rd_mux = 8'((st_lat && !tick) ? stat_snap : stat_i);
    else if (in_cnt)
      for (int i = 0; i < NUM_CNT; i++)
        if (ci == ADDR_W'(i))
          for (int b = 0; b < CNT_BYTES; b++)
            if (bi == ADDR_W'(b))
              rd_mux = (b == 0) ? src[i][7:0] : shd_q[i][b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_o <= '0;
    else if (rd_fire)
      rdata_o <= rd_mux;
  end
endmodule

module evstat_bank_chk #(
  parameter int CNT_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic rd_fire,
  input logic tick,
  input logic cnt_lat,
  input logic mode0,
  input logic sec_pin_o,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] lat0,
  input logic [7:0] rdata_o
);
  a_r9_single_effect: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !rd_fire);
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rdata_o));
  a_r1_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fire && !tick) |=> cnt0 >= $past(cnt0));
  a_r4_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_lat) |=> (lat0 == $past(cnt0)) && (cnt0 <= CNT_W'(1)));
  a_r7_rise_is_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sec_pin_o) && $past(mode0)) |-> $past(tick));
endmodule

bind evstat_bank evstat_bank_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .tick(tick),
  .cnt_lat(cnt_lat), .mode0(pin_out), .sec_pin_o(sec_pin_o),
  .cnt0(cnt_q[0]), .lat0(lat_q[0]), .rdata_o(rdata_o)
);

// File: tb/evstat_bank_tb_top.sv
module evstat_bank_tb_top;
  localparam int NC = 4, CB = 2, DIVT = 10, BASE = 16;

  logic clk = 0, rst_n = 0, ref8k = 0, pin_in = 0;
  logic cs = 0, rd = 0, wr = 0;
  logic [NC-1:0] ev = '0;
  logic [7:0] stat = '0, addr = '0, wdata = '0, rdata;
  logic pin_o, pin_oe;
  int n_cmp = 0, n_bad = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;
  always #8 ref8k = ~ref8k;

  evstat_bank #(.NUM_CNT(NC), .CNT_BYTES(CB), .NUM_STAT(8), .DIV(DIVT),
                .ADDR_W(8), .CNT_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .stat_i(stat), .ref8k_i(ref8k),
    .sec_pin_i(pin_in), .sec_pin_o(pin_o), .sec_pin_oe(pin_oe),
    .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  logic rd_prev = 0;
  always @(posedge clk) begin
    logic fire;
    fire = cs && rd && !rd_prev;
    rd_prev = cs && rd;
    if (fire && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      #1 check(it.tag, 32'(rdata), 32'(it.exp));
    end
  end

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp,
                        input logic [NC-1:0] evm, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk) begin addr = a; cs = 1; rd = 1; ev = ev | evm; end
    @(negedge clk) begin cs = 0; rd = 0; ev = ev & ~evm; end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk) begin addr = a; wdata = d; cs = 1; wr = 1; end
    @(negedge clk) begin cs = 0; wr = 0; end
  endtask

  task automatic pulse(input int ch, input int n);
    for (int k = 0; k < n; k++) @(negedge clk) ev[ch] = 1'b1;
    @(negedge clk) ev[ch] = 1'b0;
  endtask

  function automatic logic [7:0] ca(input int ch, input int b);
    return 8'(BASE + CB*ch + b);
  endfunction

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int hi, lo;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset rdata", 32'(rdata), 0);
    check("R8 reset oe", 32'(pin_oe), 0);
    rd_chk(8'h00, 8'h00, '0, "R10 mode reset");
    rd_chk(ca(0,0), 8'h00, '0, "R1 counter reset");

    pulse(0, 5);
    rd_chk(ca(0,0), 8'h05, '0, "R1 count five");
    rd_chk(ca(0,1), 8'h00, '0, "R2 upper byte");
    rd_chk(ca(0,0), 8'h00, '0, "R3 cleared by read");

    pulse(1, 300);
    rd_chk(ca(1,0), 8'h2C, '0, "R2 low byte of 300");
    pulse(1, 300);
    rd_chk(ca(1,1), 8'h01, '0, "R2 shadowed high byte");
    rd_chk(ca(1,0), 8'h2C, '0, "R2 second interval low");
    rd_chk(ca(1,1), 8'h01, '0, "R2 second interval high");

    pulse(2, 3);
    rd_chk(ca(2,0), 8'h03, 4'b0100, "R3 read with event");
    rd_chk(ca(2,0), 8'h01, '0, "R3 event kept after clear");

    pulse(2, 2);
    begin
      item_t it;
      it.exp = 8'h02; it.tag = "R9 held strobe value";
      q.push_back(it);
      @(negedge clk) begin addr = ca(2,0); cs = 1; rd = 1; end
      @(negedge clk) ev[2] = 1;
      @(negedge clk) ;
      @(negedge clk) begin cs = 0; rd = 0; ev[2] = 0; end
    end
    rd_chk(ca(2,0), 8'h02, '0, "R9 single clear per strobe");

    @(negedge clk) ev[3] = 1;
    repeat (65600) @(negedge clk);
    ev[3] = 0;
    rd_chk(ca(3,0), 8'hFF, '0, "R1 saturate low");
    rd_chk(ca(3,1), 8'hFF, '0, "R1 saturate high");

    stat = 8'hA5;
    rd_chk(8'h01, 8'hA5, '0, "R6 live status");

    wr_reg(8'h00, 8'hFF);
    rd_chk(8'h00, 8'h31, '0, "R10 mode bits kept");
    wr_reg(8'h00, 8'h30);
    rd_chk(8'h00, 8'h30, '0, "R10 mode readback");
    @(negedge clk) check("R8 oe low in input mode", 32'(pin_oe), 0);

    pulse(0, 7);
    stat = 8'h3C;
    @(negedge clk) pin_in = 1;
    repeat (4) @(negedge clk);
    stat = 8'hFF;
    rd_chk(8'h01, 8'h3C, '0, "R6 status snapshot");
    rd_chk(ca(0,0), 8'h07, '0, "R4 latched value");
    rd_chk(ca(0,1), 8'h00, '0, "R4 latched high");
    pulse(0, 3);
    rd_chk(ca(0,0), 8'h00, '0, "R5 latch cleared by read");
    pulse(0, 1);
    @(negedge clk) pin_in = 0;
    repeat (4) @(negedge clk);
    rd_chk(ca(0,0), 8'h00, '0, "R8 falling edge no tick");

    @(negedge clk) pin_in = 1;
    @(negedge clk) ;
    rd_chk(ca(0,0), 8'h04, 4'b0001, "R5 read on tick fresh");
    rd_chk(ca(0,0), 8'h04, '0, "R5 tick read kept");
    rd_chk(ca(0,0), 8'h00, '0, "R5 then cleared");
    @(negedge clk) pin_in = 0;
    repeat (4) @(negedge clk);
    pin_in = 1;
    repeat (4) @(negedge clk);
    rd_chk(ca(0,0), 8'h01, '0, "R4 tick event in new interval");

    wr_reg(8'h00, 8'h31);
    @(negedge clk) check("R7 oe high", 32'(pin_oe), 1);
    @(posedge pin_o);
    hi = 0; lo = 0;
    @(negedge clk);
    while (pin_o) begin hi++; @(negedge clk); end
    while (!pin_o) begin lo++; @(negedge clk); end
    check("R7 high time", 32'(hi), 20);
    check("R7 period", 32'(hi + lo), 40);
    pulse(1, 9);
    @(posedge pin_o);
    repeat (2) @(negedge clk);
    rd_chk(ca(1,0), 8'h09, '0, "R7 divider tick latches");

    repeat (4) @(negedge clk);
    check("R9 all reads observed", 32'(q.size()), 0);
    finish_run();
  end
endmodule